// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Freeze

This block keeps calendar time in packed BCD. It counts hundredths of a second, seconds, minutes, hours, weekday, date, month and year, and it advances on a one-cycle 100 Hz tick pulse. It holds two copies of the time. A running copy counts all the time. A visible copy is what the register bus reads. Software clears a transfer-enable bit to freeze the visible copy so that it can read or write the fields safely. The running copy keeps counting during the freeze, and it is copied out again once transfer is re-enabled, so no time is lost.

The seconds-to-years part of the running copy advances on the tick that takes hundredths to 99. It becomes visible on the tick that rolls hundredths from 99 to 00. Hours can be kept in 12-hour form with a PM flag or in 24-hour form. The month register also carries an active-low oscillator-run bit and an active-low square-wave enable bit. The square-wave enable appears as a plain output.

Register map (addr): 0 hundredths, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 date, 6 month, 7 year, 8 control. Any other address reads 0x00.

Top module: `tod_freeze_clock`

## Requirements
- R1: After reset the registers read hundredths 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0xC1 and control 0x80. The 0xC1 means the oscillator is stopped and the square wave is disabled; the 0x80 means transfer is enabled.
- R2: The oscillator runs when month bit 7 is 0. While it runs, each tick advances the hundredths field by one in BCD, with 0x99 followed by 0x00. While month bit 7 is 1, ticks change neither copy.
- R3: The running seconds-to-years fields advance on the tick that takes hundredths from 98 to 99. The visible fields take these values only on the tick that rolls hundredths from 99 to 00, so the visible seconds do not change while hundredths reads 0x99.
- R4: When control bit 7 is 0, every visible field holds while the running copy keeps counting. After bit 7 returns to 1, the next tick shows the running hundredths, and the next rollover shows the running seconds-to-years fields.
- R5: A seconds carry from 59 to 00 advances minutes. A minutes carry advances hours. In 24-hour mode, hours go from 0x23 to 0x00 with a day carry. The day carry advances the weekday, and weekday 7 wraps to 1.
- R6: Hours bit 6 = 1 selects 12-hour mode, with bit 5 as PM (1 = PM). The hour sequence is 12, 1, …, 11. PM toggles on the step from 11 to 12, and PM 11 to AM 12 produces a day carry.
- R7: The date wraps to 01 after 28 or 29 (February), 30 (April, June, September, November) or 31 (all other months), and the month advances. February has 29 days when the BCD year is divisible by 4, and year 00 counts as divisible by 4.
- R8: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00.
- R9: Unused bits read 0 whatever is written. The masks are: seconds, minutes and hours 0x7F; weekday 0x07; date 0x3F; month bit 5; control bits 6:0.
- R10: A bus write to a time field sets the visible copy and the running copy in the same cycle, including during a freeze.
- R11: Output `sqw_off` equals month bit 6, and it is 1 after reset.
- R12: If a write and a tick land in the same cycle, the written value wins for the written field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_100hz | input | 1 | One-cycle pulse every 0.01 s |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the addressed visible register |
| sqw_off | output | 1 | Square-wave disable (month bit 6) |

## Verification
The hardest state to reach from the ports is a running copy that has moved ahead of a frozen visible copy. It has to be observed at the exact tick where the two copies meet again. The bench freezes the visible copy and loads a field during the freeze. It then counts a known number of ticks across the 98-to-99 and 99-to-00 boundaries, so that the running value can only be seen through the delayed transfer. Calendar corners such as leap Februaries, year wrap and PM 11 to AM 12 are each placed one second before their rollover and then stepped with two ticks.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int NUM_REGS = 9;
  localparam int A_HUND = 0;
  localparam int A_SEC  = 1;
  localparam int A_MIN  = 2;
  localparam int A_HR   = 3;
  localparam int A_WDAY = 4;
  localparam int A_DATE = 5;
  localparam int A_MON  = 6;
  localparam int A_YR   = 7;
  localparam int A_CTRL = 8;

  localparam logic [7:0] MASK_SEC  = 8'h7F;
  localparam logic [7:0] MASK_MIN  = 8'h7F;
  localparam logic [7:0] MASK_HR   = 8'h7F;
  localparam logic [7:0] MASK_WDAY = 8'h07;
  localparam logic [7:0] MASK_DATE = 8'h3F;
  localparam logic [7:0] MASK_MON  = 8'h1F;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hr;
    logic [7:0] wday;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] yr;
  } tod_upper_t;

  function automatic logic [7:0] bcd_inc(input logic [7:0] x);
    if (x[3:0] == 4'd9) return {x[7:4] + 4'd1, 4'h0};
    else                return x + 8'd1;
  endfunction

  // Two-digit BCD year divisible by four: even tens with 0/4/8, odd tens with 2/6
  function automatic logic is_leap(input logic [7:0] yr);
    if (yr[4]) return (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       return (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/tod_hour_step.sv
module tod_hour_step (
  input  logic [6:0] hr,
  output logic [7:0] hr_nxt,
  output logic       day_carry
);
  import tod_pkg::*;

  logic [7:0] hv12, hv24, inc12, inc24;

  always_comb begin
    hv12      = {3'b000, hr[4:0]};
    hv24      = {2'b00, hr[5:0]};
    inc12     = bcd_inc(hv12);
    inc24     = bcd_inc(hv24);
    hr_nxt    = 8'h00;
    day_carry = 1'b0;
    if (hr[6]) begin
      if (hv12 == 8'h12) begin
        hr_nxt = {2'b01, hr[5], 5'h01};
      end else if (hv12 == 8'h11) begin
        hr_nxt    = {2'b01, ~hr[5], 5'h12};
        day_carry = hr[5];
      end else begin
        hr_nxt = {2'b01, hr[5], inc12[4:0]};
      end
    end else begin
      if (hv24 == 8'h23) begin
        hr_nxt    = 8'h00;
        day_carry = 1'b1;
      end else begin
        hr_nxt = {2'b00, inc24[5:0]};
      end
    end
  end
endmodule

// File: rtl/tod_date_step.sv
module tod_date_step (
  input  logic       day_carry,
  input  logic [7:0] wday,
  input  logic [7:0] date,
  input  logic [7:0] mon,
  input  logic [7:0] yr,
  output logic [7:0] wday_nxt,
  output logic [7:0] date_nxt,
  output logic [7:0] mon_nxt,
  output logic [7:0] yr_nxt
);
  import tod_pkg::*;

  logic [7:0] last_day;

  always_comb begin
    last_day = month_days(mon, yr);
    wday_nxt = wday;
    date_nxt = date;
    mon_nxt  = mon;
    yr_nxt   = yr;
    if (day_carry) begin
      wday_nxt = (wday >= 8'h07) ? 8'h01 : wday + 8'h01;
      if (date >= last_day) begin
        date_nxt = 8'h01;
        if (mon >= 8'h12) begin
          mon_nxt = 8'h01;
          yr_nxt  = (yr == 8'h99) ? 8'h00 : bcd_inc(yr);
        end else begin
          mon_nxt = bcd_inc(mon);
        end
      end else begin
        date_nxt = bcd_inc(date);
      end
    end
  end
endmodule

// File: rtl/tod_sec_advance.sv
module tod_sec_advance
  import tod_pkg::*;
(
  input  tod_upper_t cur,
  output tod_upper_t nxt
);
  logic       sec_wrap, min_wrap, hr_carry;
  logic [7:0] hr_step;

  tod_hour_step hour_i (
    .hr        (cur.hr[6:0]),
    .hr_nxt    (hr_step),
    .day_carry (hr_carry)
  );

  tod_date_step date_i (
    .day_carry (sec_wrap & min_wrap & hr_carry),
    .wday      (cur.wday),
    .date      (cur.date),
    .mon       (cur.mon),
    .yr        (cur.yr),
    .wday_nxt  (nxt.wday),
    .date_nxt  (nxt.date),
    .mon_nxt   (nxt.mon),
    .yr_nxt    (nxt.yr)
  );

  always_comb begin
    sec_wrap = (cur.sec == 8'h59);
    min_wrap = (cur.min == 8'h59);
    nxt.sec  = sec_wrap ? 8'h00 : bcd_inc(cur.sec);
    nxt.min  = cur.min;
    nxt.hr   = cur.hr;
    if (sec_wrap) begin
      nxt.min = min_wrap ? 8'h00 : bcd_inc(cur.min);
      if (min_wrap) nxt.hr = hr_step | {cur.hr[7], 7'b0};
    end
  end
endmodule

// File: rtl/tod_freeze_clock.sv
module tod_freeze_clock
  import tod_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_100hz,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              sqw_off
);

  // Reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_q = rst_pipe[SYNC_STAGES-1];

  // State
  logic [7:0] hund_int, hund_vis, hund_int_n, hund_vis_n;
  tod_upper_t up_int, up_vis, up_int_n, up_vis_n, up_adv;
  logic       te, osc_off, te_n, osc_off_n, sqw_off_n;
  logic       tick_go;

  tod_sec_advance adv_i (
    .cur (up_int),
    .nxt (up_adv)
  );

  always_comb begin
    tick_go    = tick_100hz & ~osc_off;
    hund_int_n = hund_int;
    hund_vis_n = hund_vis;
    up_int_n   = up_int;
    up_vis_n   = up_vis;
    te_n       = te;
    osc_off_n  = osc_off;
    sqw_off_n  = sqw_off;

    if (tick_go) begin
      hund_int_n = (hund_int == 8'h99) ? 8'h00 : bcd_inc(hund_int);
      if (hund_int == 8'h98) up_int_n = up_adv;
      if (te) begin
        hund_vis_n = hund_int_n;
        if (hund_int == 8'h99) up_vis_n = up_int;
      end
    end

    if (wr_en) begin
      if (addr == ADDR_W'(A_HUND)) begin
        hund_int_n = wr_data;
        hund_vis_n = wr_data;
      end
      if (addr == ADDR_W'(A_SEC)) begin
        up_int_n.sec = wr_data & MASK_SEC;
        up_vis_n.sec = wr_data & MASK_SEC;
      end
      if (addr == ADDR_W'(A_MIN)) begin
        up_int_n.min = wr_data & MASK_MIN;
        up_vis_n.min = wr_data & MASK_MIN;
      end
      if (addr == ADDR_W'(A_HR)) begin
        up_int_n.hr = wr_data & MASK_HR;
        up_vis_n.hr = wr_data & MASK_HR;
      end
      if (addr == ADDR_W'(A_WDAY)) begin
        up_int_n.wday = wr_data & MASK_WDAY;
        up_vis_n.wday = wr_data & MASK_WDAY;
      end
      if (addr == ADDR_W'(A_DATE)) begin
        up_int_n.date = wr_data & MASK_DATE;
        up_vis_n.date = wr_data & MASK_DATE;
      end
      if (addr == ADDR_W'(A_MON)) begin
        up_int_n.mon = wr_data & MASK_MON;
        up_vis_n.mon = wr_data & MASK_MON;
        osc_off_n    = wr_data[7];
        sqw_off_n    = wr_data[6];
      end
      if (addr == ADDR_W'(A_YR)) begin
        up_int_n.yr = wr_data;
        up_vis_n.yr = wr_data;
      end
      if (addr == ADDR_W'(A_CTRL)) te_n = wr_data[7];
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hund_int <= 8'h00;
      hund_vis <= 8'h00;
      up_int   <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, wday: 8'h01,
                    date: 8'h01, mon: 8'h01, yr: 8'h00};
      up_vis   <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, wday: 8'h01,
                    date: 8'h01, mon: 8'h01, yr: 8'h00};
      te       <= 1'b1;
      osc_off  <= 1'b1;
      sqw_off  <= 1'b1;
    end else begin
      hund_int <= hund_int_n;
      hund_vis <= hund_vis_n;
      up_int   <= up_int_n;
      up_vis   <= up_vis_n;
      te       <= te_n;
      osc_off  <= osc_off_n;
      sqw_off  <= sqw_off_n;
    end
  end

  // Read side
  logic [7:0] view [NUM_REGS];

  always_comb begin
    view[A_HUND] = hund_vis;
    view[A_SEC]  = up_vis.sec;
    view[A_MIN]  = up_vis.min;
    view[A_HR]   = up_vis.hr;
    view[A_WDAY] = up_vis.wday;
    view[A_DATE] = up_vis.date;
    view[A_MON]  = up_vis.mon | {osc_off, sqw_off, 6'b0};
    view[A_YR]   = up_vis.yr;
    view[A_CTRL] = {te, 7'b0};
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_data = view[i];
    end
  end

endmodule

// File: rtl/tod_freeze_clock_chk.sv
module tod_freeze_clock_chk
  import tod_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_go,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rd_data,
  input logic [7:0]        hund_int,
  input logic [7:0]        hund_vis,
  input tod_upper_t        up_int,
  input tod_upper_t        up_vis,
  input logic              te,
  input logic              osc_off
);

  assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_off && !wr_en) |=> ($stable(hund_int) && $stable(up_int)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_go && !wr_en) |=> ($stable(hund_int) && $stable(up_int)));

  assert_upper_only_at_rollover_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(tick_go && hund_int == 8'h99)) |=> $stable(up_vis));

  assert_rollover_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (te && tick_go && hund_int == 8'h99 && !wr_en) |=> (up_vis == $past(up_int)));

  assert_freeze_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !wr_en) |=> ($stable(hund_vis) && $stable(up_vis)));

  assert_weekday_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_WDAY)) |-> (rd_data[7:3] == 5'b0));

  assert_seconds_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(A_SEC)) |-> (rd_data[7] == 1'b0));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(NUM_REGS)) |-> (rd_data == 8'h00));

endmodule

bind tod_freeze_clock tod_freeze_clock_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk      (clk),
  .rst_n    (rst_q),
  .tick_go  (tick_go),
  .wr_en    (wr_en),
  .addr     (addr),
  .rd_data  (rd_data),
  .hund_int (hund_int),
  .hund_vis (hund_vis),
  .up_int   (up_int),
  .up_vis   (up_vis),
  .te       (te),
  .osc_off  (osc_off)
);

// File: tb/tod_freeze_clock_tb_top.sv
module tod_freeze_clock_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 4;

  localparam logic [3:0] RH = 4'd0, RS = 4'd1, RM = 4'd2, RHR = 4'd3, RWD = 4'd4,
                         RDT = 4'd5, RMO = 4'd6, RYR = 4'd7, RCT = 4'd8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_100hz = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wr_data = '0;
  logic [7:0]        rd_data;
  logic              sqw_off;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_freeze_clock #(.ADDR_W(ADDR_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_100hz (tick_100hz),
    .wr_en      (wr_en),
    .addr       (addr),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .sqw_off    (sqw_off)
  );

  // start hr,min,sec,wday,date,mon,yr then expected after one second
  typedef struct packed {
    logic [7:0] hr, mi, se, wd, dt, mo, yr;
    logic [7:0] ehr, emi, ese, ewd, edt, emo, eyr;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{8'h12,8'h34,8'h56,8'h03,8'h15,8'h06,8'h21, 8'h12,8'h34,8'h57,8'h03,8'h15,8'h06,8'h21}, // R3
    '{8'h10,8'h59,8'h59,8'h03,8'h15,8'h06,8'h21, 8'h11,8'h00,8'h00,8'h03,8'h15,8'h06,8'h21}, // R5
    '{8'h09,8'h59,8'h59,8'h01,8'h05,8'h06,8'h21, 8'h10,8'h00,8'h00,8'h01,8'h05,8'h06,8'h21}, // R5
    '{8'h19,8'h59,8'h59,8'h01,8'h05,8'h06,8'h21, 8'h20,8'h00,8'h00,8'h01,8'h05,8'h06,8'h21}, // R5
    '{8'h23,8'h59,8'h59,8'h07,8'h15,8'h06,8'h21, 8'h00,8'h00,8'h00,8'h01,8'h16,8'h06,8'h21}, // R5
    '{8'h23,8'h59,8'h59,8'h02,8'h30,8'h04,8'h21, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h05,8'h21}, // R7
    '{8'h23,8'h59,8'h59,8'h02,8'h31,8'h01,8'h21, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h02,8'h21}, // R7
    '{8'h23,8'h59,8'h59,8'h02,8'h28,8'h02,8'h23, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h23}, // R7
    '{8'h23,8'h59,8'h59,8'h02,8'h28,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h24}, // R7
    '{8'h23,8'h59,8'h59,8'h02,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h24}, // R7
    '{8'h23,8'h59,8'h59,8'h02,8'h28,8'h02,8'h00, 8'h00,8'h00,8'h00,8'h03,8'h29,8'h02,8'h00}, // R7
    '{8'h23,8'h59,8'h59,8'h02,8'h28,8'h02,8'h10, 8'h00,8'h00,8'h00,8'h03,8'h01,8'h03,8'h10}, // R7
    '{8'h23,8'h59,8'h59,8'h05,8'h30,8'h09,8'h21, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h10,8'h21}, // R7
    '{8'h23,8'h59,8'h59,8'h06,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h01,8'h00}, // R8
    '{8'h23,8'h59,8'h59,8'h06,8'h31,8'h12,8'h19, 8'h00,8'h00,8'h00,8'h07,8'h01,8'h01,8'h20}, // R8
    '{8'h51,8'h59,8'h59,8'h04,8'h10,8'h06,8'h21, 8'h72,8'h00,8'h00,8'h04,8'h10,8'h06,8'h21}, // R6
    '{8'h71,8'h59,8'h59,8'h04,8'h10,8'h06,8'h21, 8'h52,8'h00,8'h00,8'h05,8'h11,8'h06,8'h21}, // R6
    '{8'h52,8'h59,8'h59,8'h04,8'h10,8'h06,8'h21, 8'h41,8'h00,8'h00,8'h04,8'h10,8'h06,8'h21}, // R6
    '{8'h69,8'h59,8'h59,8'h04,8'h10,8'h06,8'h21, 8'h70,8'h00,8'h00,8'h04,8'h10,8'h06,8'h21}  // R6
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_100hz = 1'b1;
      @(negedge clk);
      tick_100hz = 1'b0;
    end
  endtask

  task automatic expect_reg(input logic [3:0] a, input logic [7:0] e, input string tag);
    logic [7:0] v;
    rd(a, v);
    check(v == e, tag, 64'(v), 64'(e));
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [7:0] got [7];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    expect_reg(RH,  8'h00, "R1 hundredths");
    expect_reg(RS,  8'h00, "R1 seconds");
    expect_reg(RM,  8'h00, "R1 minutes");
    expect_reg(RHR, 8'h00, "R1 hours");
    expect_reg(RWD, 8'h01, "R1 weekday");
    expect_reg(RDT, 8'h01, "R1 date");
    expect_reg(RMO, 8'hC1, "R1 month");
    expect_reg(RYR, 8'h00, "R1 year");
    expect_reg(RCT, 8'h80, "R1 control");
    check(sqw_off == 1'b1, "R11 reset sqw_off", 64'(sqw_off), 64'd1);

    // R2 oscillator stopped: ticks ignored
    tick(3);
    expect_reg(RH, 8'h00, "R2 stopped ticks ignored");

    // Vector table: one second across each corner
    for (int k = 0; k < NVEC; k++) begin
      wr(RHR, VECS[k].hr);
      wr(RM,  VECS[k].mi);
      wr(RS,  VECS[k].se);
      wr(RWD, VECS[k].wd);
      wr(RDT, VECS[k].dt);
      wr(RMO, VECS[k].mo);
      wr(RYR, VECS[k].yr);
      wr(RH,  8'h98);
      tick(2);
      rd(RHR, got[0]); rd(RM, got[1]); rd(RS, got[2]); rd(RWD, got[3]);
      rd(RDT, got[4]); rd(RMO, got[5]); rd(RYR, got[6]);
      check({got[0],got[1],got[2],got[3],got[4],got[5],got[6]} ==
            {VECS[k].ehr,VECS[k].emi,VECS[k].ese,VECS[k].ewd,VECS[k].edt,VECS[k].emo,VECS[k].eyr},
            $sformatf("R5 R6 R7 R8 vector row %0d", k),
            {8'h00,got[0],got[1],got[2],got[3],got[4],got[5],got[6]},
            {8'h00,VECS[k].ehr,VECS[k].emi,VECS[k].ese,VECS[k].ewd,VECS[k].edt,VECS[k].emo,VECS[k].eyr});
    end

    // R11 square-wave enable follows month bit 6 (osc running, sqw on)
    wr(RMO, 8'h01);
    check(sqw_off == 1'b0, "R11 sqw enabled", 64'(sqw_off), 64'd0);

    // R2 hundredths stepping in BCD
    wr(RH, 8'h00);
    tick(3);
    expect_reg(RH, 8'h03, "R2 three ticks");
    wr(RH, 8'h09);
    tick(1);
    expect_reg(RH, 8'h10, "R2 BCD digit carry");

    // R3 visible upper fields change only at 99 -> 00
    wr(RS, 8'h10);
    wr(RH, 8'h98);
    tick(1);
    expect_reg(RH, 8'h99, "R3 hundredths at 99");
    expect_reg(RS, 8'h10, "R3 seconds held while 99");
    tick(1);
    expect_reg(RH, 8'h00, "R3 hundredths rolled");
    expect_reg(RS, 8'h11, "R3 seconds after rollover");

    // R4 freeze: visible holds, running copy counts
    wr(RS, 8'h20);
    wr(RH, 8'h00);
    wr(RCT, 8'h00);
    expect_reg(RCT, 8'h00, "R4 transfer disabled");
    tick(250);
    expect_reg(RH, 8'h00, "R4 frozen hundredths");
    expect_reg(RS, 8'h20, "R4 frozen seconds");
    wr(RCT, 8'h80);
    tick(1);
    expect_reg(RH, 8'h51, "R4 hundredths resync");
    expect_reg(RS, 8'h20, "R4 seconds wait for rollover");
    tick(49);
    expect_reg(RH, 8'h00, "R4 rollover hundredths");
    expect_reg(RS, 8'h23, "R4 no time lost");

    // R10 write during freeze reaches both copies
    wr(RCT, 8'h00);
    wr(RS, 8'h30);
    wr(RH, 8'h98);
    expect_reg(RS, 8'h30, "R10 visible write during freeze");
    tick(2);
    expect_reg(RS, 8'h30, "R10 still frozen");
    expect_reg(RH, 8'h98, "R10 hundredths still frozen");
    wr(RCT, 8'h80);
    tick(100);
    expect_reg(RS, 8'h32, "R10 running copy took write");

    // R12 write coincident with tick wins
    @(negedge clk);
    wr_en = 1'b1; addr = RH; wr_data = 8'h55; tick_100hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_100hz = 1'b0;
    expect_reg(RH, 8'h55, "R12 write beats tick");

    // R9 unused bits read zero
    wr(RS,  8'hFF); expect_reg(RS,  8'h7F, "R9 seconds mask");
    wr(RM,  8'hFF); expect_reg(RM,  8'h7F, "R9 minutes mask");
    wr(RHR, 8'hFF); expect_reg(RHR, 8'h7F, "R9 hours mask");
    wr(RWD, 8'hFF); expect_reg(RWD, 8'h07, "R9 weekday mask");
    wr(RDT, 8'hFF); expect_reg(RDT, 8'h3F, "R9 date mask");
    wr(RMO, 8'hFF); expect_reg(RMO, 8'hDF, "R9 month mask");
    wr(RCT, 8'hFF); expect_reg(RCT, 8'h80, "R9 control mask");
    expect_reg(4'd9, 8'h00, "R9 unmapped address");

    // R2 again: stopped after month bit 7 set
    wr(RH, 8'h20);
    tick(4);
    expect_reg(RH, 8'h20, "R2 stopped again");

    // R11 square wave off via month bit 6
    wr(RMO, 8'h81);
    check(sqw_off == 1'b0, "R11 bit6 clear", 64'(sqw_off), 64'd0);
    wr(RMO, 8'h41);
    check(sqw_off == 1'b1, "R11 bit6 set", 64'(sqw_off), 64'd1);

    report();
  end

endmodule